// File: doc/BRIEF.md
# Event Capture DMA with Gap and Event Timeouts

This block moves one event's readout words from a streaming source into a local buffer RAM and then raises a single interrupt, so the host does no work per word. An arming pulse starts an event. The engine first writes a two-word header, the running event number and the word count of the event before, at the bottom of the buffer. It then opens a capture window and stores each arriving word at the next address.

Two programmable limits close the event. The gap limit is the normal way to finish: once the first word has arrived, a run of idle cycles of the programmed length means the source is done. The event limit bounds the whole event from the arming edge and ends a transfer that never goes quiet. When the buffer fills, the last location is kept and later words are dropped and flagged. The interrupt is a level with a status code. It stays up until the host acknowledges it. With automatic re-arm enabled, the acknowledge itself starts the next event, so a stream of events runs without per-event setup.

A synchronous read port gives the host the buffer contents, both between events and while the interrupt is pending.

Top module: `evdma_top`

## Requirements
- R1: After reset, `busy`, `cap_open`, `irq` and `irq_status` are all zero. The first event after reset carries event number 0 and a previous length of 0.
- R2: An `arm` pulse while idle is the arming edge (edge 0). The header is written on the next two edges. `cap_open` is high after edge 2. The first word that can be accepted is the one presented at edge 3.
- R3: While the window is open, each word with `in_valid` high is stored at addresses 2, 3, 4 and upward, in arrival order. Words presented outside the window are ignored.
- R4: Once a word has been accepted, G consecutive edges with no word end the event after the G-th such edge (a programmed gap limit of 0 acts as 1). `irq` then rises with `irq_status[1:0]` = 01.
- R5: If the event is still open at edge max(L,3), counted from the arming edge (L = event limit), it ends with `irq_status[1:0]` = 10. A word presented at that edge is discarded. If the gap end falls on the same edge, the gap end wins.
- R6: Address DEPTH-1 is the last one written. Any later word of the event is not stored, sets `irq_status[2]`, and still restarts the gap count.
- R7: `irq` holds until an `ack` while it is high; it is low after that edge. An `ack` while `irq` is low has no effect.
- R8: With `cfg_auto_rearm` high, the acknowledge edge is the arming edge of the next event. Otherwise the engine goes idle and waits for `arm`. An `arm` while busy has no effect.
- R9: Buffer word 0 holds the event number, which rises by one per event (modulo 2^DW). Word 1 holds the number of words stored by the previous event.
- R10: `rd_data` returns the buffer word at `rd_addr` one edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_evt_limit | input | EVW | Whole-event limit in cycles from the arming edge |
| cfg_gap_limit | input | GPW | Idle-gap limit in cycles that closes an event |
| cfg_auto_rearm | input | 1 | Acknowledge also starts the next event |
| arm | input | 1 | Start an event when idle |
| ack | input | 1 | Host acknowledge of the pending interrupt |
| in_valid | input | 1 | Data word present this cycle |
| in_data | input | DW | Data word |
| rd_addr | input | AW | Buffer read address |
| rd_data | output | DW | Buffer read data, one cycle after the address |
| busy | output | 1 | An event is in progress or awaits acknowledge |
| cap_open | output | 1 | Capture window is open |
| irq | output | 1 | Event-finished interrupt level |
| irq_status | output | 3 | [1:0] end cause (01 gap, 10 event limit), [2] overflow |

## Verification
A control fault shows up at the ports within one edge. A header phase that slips, or a window that opens early or late, moves `cap_open` and shifts every stored word by one address in the readback. A wrong gap or event count moves the rising edge of `irq` off the cycle the bench predicts from its own schedule of words, and it changes the end code when the two limits land close together. A pointer, overflow or length fault stays out of sight until the buffer is read back or the next header is written. The bench therefore reads the buffer back after every event and checks both header words against its running event number and previous length.

// File: rtl/evdma_pkg.sv
`timescale 1ns/1ps
package evdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR_SEQ,
    ST_HDR_LEN,
    ST_CAPT,
    ST_DONE
  } evdma_state_e;

  localparam logic [1:0] END_NONE = 2'b00;
  localparam logic [1:0] END_GAP  = 2'b01;
  localparam logic [1:0] END_EVT  = 2'b10;
endpackage

// File: rtl/evdma_timer.sv
`timescale 1ns/1ps
// Saturating up-counter that flags when the cycle being counted reaches the limit.
module evdma_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;
  logic [W:0]   cnt_next;

  assign cnt_next = {1'b0, cnt} + (W+1)'(1);
  assign hit      = en && (cnt_next >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (en && (cnt != '1)) begin
      cnt <= cnt + W'(1);
    end
  end

  AST_TMR_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (!clr && en && cnt == '1) |=> (cnt == '1)); // R5
  AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0)); // R4
endmodule

// File: rtl/evdma_buf.sv
`timescale 1ns/1ps
// Simple dual-port buffer: one write port, one registered read port.
module evdma_buf #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/evdma_ctrl.sv
`timescale 1ns/1ps
module evdma_ctrl
  import evdma_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          ack,
  input  logic          auto_rearm,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          gap_hit,
  input  logic          evt_hit,
  output logic          tmr_start,
  output logic          evt_run,
  output logic          gap_run,
  output logic          gap_clr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          cap_open,
  output logic          irq,
  output logic [2:0]    irq_status
);
  localparam logic [AW-1:0] FIRST_DATA = AW'(2);
  localparam logic [AW-1:0] LAST_ADDR  = '1;

  evdma_state_e  state;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] len_cnt;
  logic [DW-1:0] seq_num;
  logic [DW-1:0] prev_len;
  logic          full;
  logic          seen;
  logic          ovf;
  logic [1:0]    end_code;
  logic          in_capt;
  logic          take;

  assign in_capt   = (state == ST_CAPT);
  assign tmr_start = ((state == ST_IDLE) && arm) ||
                     ((state == ST_DONE) && ack && auto_rearm);
  assign evt_run   = (state == ST_HDR_SEQ) || (state == ST_HDR_LEN) || in_capt;
  assign gap_run   = in_capt && seen && !in_valid;
  assign take      = in_capt && in_valid && !evt_hit;
  assign gap_clr   = tmr_start || take;

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = wr_ptr;
    wr_data = in_data;
    case (state)
      ST_HDR_SEQ: begin
        wr_en   = 1'b1;
        wr_addr = AW'(0);
        wr_data = seq_num;
      end
      ST_HDR_LEN: begin
        wr_en   = 1'b1;
        wr_addr = AW'(1);
        wr_data = prev_len;
      end
      ST_CAPT: begin
        wr_en = take && !gap_hit && !full;
      end
      default: ;
    endcase
  end

  assign busy       = (state != ST_IDLE);
  assign cap_open   = in_capt;
  assign irq_status = {ovf, end_code};

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      wr_ptr   <= FIRST_DATA;
      len_cnt  <= '0;
      seq_num  <= '0;
      prev_len <= '0;
      full     <= 1'b0;
      seen     <= 1'b0;
      ovf      <= 1'b0;
      end_code <= END_NONE;
      irq      <= 1'b0;
    end else begin
      if (tmr_start) begin
        wr_ptr   <= FIRST_DATA;
        len_cnt  <= '0;
        full     <= 1'b0;
        seen     <= 1'b0;
        ovf      <= 1'b0;
        end_code <= END_NONE;
      end
      case (state)
        ST_IDLE: begin
          if (arm) state <= ST_HDR_SEQ;
        end
        ST_HDR_SEQ: state <= ST_HDR_LEN;
        ST_HDR_LEN: state <= ST_CAPT;
        ST_CAPT: begin
          if (gap_hit) begin
            state    <= ST_DONE;
            end_code <= END_GAP;
            irq      <= 1'b1;
          end else if (evt_hit) begin
            state    <= ST_DONE;
            end_code <= END_EVT;
            irq      <= 1'b1;
          end else if (in_valid) begin
            seen <= 1'b1;
            if (full) begin
              ovf <= 1'b1;
            end else begin
              len_cnt <= len_cnt + AW'(1);
              if (wr_ptr == LAST_ADDR) full <= 1'b1;
              else wr_ptr <= wr_ptr + AW'(1);
            end
          end
        end
        ST_DONE: begin
          if (ack) begin
            irq      <= 1'b0;
            seq_num  <= seq_num + DW'(1);
            prev_len <= DW'(len_cnt);
            state    <= auto_rearm ? ST_HDR_SEQ : ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_HDR_PAIR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && state == ST_HDR_SEQ) |=> (wr_en && wr_addr == AW'(1))); // R2
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq && !ack) |=> irq); // R7
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
    (irq && ack) |=> !irq); // R7
  AST_END_CODE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $onehot(end_code)); // R4
  AST_PTR_MONO: assert property (@(posedge clk) disable iff (rst)
    (in_capt && $past(in_capt)) |-> (wr_ptr >= $past(wr_ptr))); // R6
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (in_capt && ovf) |=> ovf); // R6
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> (seq_num == $past(seq_num) + DW'(1))); // R9
endmodule

// File: rtl/evdma_top.sv
`timescale 1ns/1ps
module evdma_top #(
  parameter int DW  = 16,
  parameter int AW  = 8,
  parameter int EVW = 20,
  parameter int GPW = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [EVW-1:0] cfg_evt_limit,
  input  logic [GPW-1:0] cfg_gap_limit,
  input  logic           cfg_auto_rearm,
  input  logic           arm,
  input  logic           ack,
  input  logic           in_valid,
  input  logic [DW-1:0]  in_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic           busy,
  output logic           cap_open,
  output logic           irq,
  output logic [2:0]     irq_status
);
  logic          tmr_start;
  logic          evt_run;
  logic          gap_run;
  logic          gap_clr;
  logic          evt_hit;
  logic          gap_hit;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  evdma_timer #(.W(EVW)) u_evt_tmr (
    .clk   (clk),
    .rst   (rst),
    .clr   (tmr_start),
    .en    (evt_run),
    .limit (cfg_evt_limit),
    .hit   (evt_hit)
  );

  evdma_timer #(.W(GPW)) u_gap_tmr (
    .clk   (clk),
    .rst   (rst),
    .clr   (gap_clr),
    .en    (gap_run),
    .limit (cfg_gap_limit),
    .hit   (gap_hit)
  );

  evdma_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .arm        (arm),
    .ack        (ack),
    .auto_rearm (cfg_auto_rearm),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .gap_hit    (gap_hit),
    .evt_hit    (evt_hit),
    .tmr_start  (tmr_start),
    .evt_run    (evt_run),
    .gap_run    (gap_run),
    .gap_clr    (gap_clr),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .busy       (busy),
    .cap_open   (cap_open),
    .irq        (irq),
    .irq_status (irq_status)
  );

  evdma_buf #(.DW(DW), .AW(AW)) u_buf (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  AST_IRQ_CLOSED: assert property (@(posedge clk) disable iff (rst)
    irq |-> !cap_open); // R5
  AST_ARM_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && arm && !irq) |=> busy); // R8
  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq) && irq_status[1:0] == 2'b01) |-> $past(!in_valid)); // R4
endmodule

// File: tb/evdma_top_bench.sv
`timescale 1ns/1ps
module evdma_top_bench;
  localparam int DW    = 16;
  localparam int AW    = 8;
  localparam int EVW   = 20;
  localparam int GPW   = 12;
  localparam int DEPTH = 1 << AW;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [EVW-1:0] cfg_evt_limit = '0;
  logic [GPW-1:0] cfg_gap_limit = '0;
  logic           cfg_auto_rearm = 1'b0;
  logic           arm = 1'b0;
  logic           ack = 1'b0;
  logic           in_valid = 1'b0;
  logic [DW-1:0]  in_data = '0;
  logic [AW-1:0]  rd_addr = '0;
  logic [DW-1:0]  rd_data;
  logic           busy;
  logic           cap_open;
  logic           irq;
  logic [2:0]     irq_status;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] exp_mem [DEPTH];
  int exp_seq = 0;
  int exp_prev = 0;
  int last_stored = 0;

  always #2 clk = ~clk;

  evdma_top #(.DW(DW), .AW(AW), .EVW(EVW), .GPW(GPW)) u_evdma_top (
    .clk            (clk),
    .rst            (rst),
    .cfg_evt_limit  (cfg_evt_limit),
    .cfg_gap_limit  (cfg_gap_limit),
    .cfg_auto_rearm (cfg_auto_rearm),
    .arm            (arm),
    .ack            (ack),
    .in_valid       (in_valid),
    .in_data        (in_data),
    .rd_addr        (rd_addr),
    .rd_data        (rd_data),
    .busy           (busy),
    .cap_open       (cap_open),
    .irq            (irq),
    .irq_status     (irq_status)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] expv, input string what);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // One event from its arming edge to the pending interrupt, then buffer readback.
  task automatic run_event(input bit started, input int nwords, input int maxgap,
                           input int lead, input bit junk, input int poke_k,
                           input int lim_evt, input int lim_gap);
    int k = 0;
    int wi = 0;
    int next_k;
    int last = 0;
    int stored = 0;
    int code = 0;
    int gc;
    bit seen = 1'b0;
    bit ovf = 1'b0;
    bit vld;
    logic [DW-1:0] d;
    logic [DW-1:0] ev;
    cfg_evt_limit = EVW'(lim_evt);
    cfg_gap_limit = GPW'(lim_gap);
    gc = (lim_gap == 0) ? 1 : lim_gap;
    if (!started) begin
      arm = 1'b1;
      @(negedge clk);
      arm = 1'b0;
    end
    check("R2", busy, 1, "busy after arming edge");
    next_k = 3 + lead;
    while (code == 0 && k < 20000) begin
      k++;
      vld = 1'b0;
      d = DW'($urandom);
      if (junk && k <= 2) begin
        vld = 1'b1;
      end else if (wi < nwords && k == next_k) begin
        vld = 1'b1;
        wi++;
        next_k = k + 1 + int'($urandom_range(maxgap, 0));
      end
      if (k == poke_k) begin
        arm = 1'b1;   // R8: ignored while busy
        ack = 1'b1;   // R7: ignored while irq low
      end
      in_valid = vld;
      in_data = d;
      if (k >= 3) begin
        if (seen && !vld && (k - last) >= gc) code = 1;
        else if (k >= lim_evt) code = 2;
        else if (vld) begin
          seen = 1'b1;
          last = k;
          if (stored == DEPTH - 2) ovf = 1'b1;
          else begin
            exp_mem[2 + stored] = d;
            stored++;
          end
        end
      end
      @(negedge clk);
      in_valid = 1'b0;
      arm = 1'b0;
      ack = 1'b0;
      check((code == 2) ? "R5" : "R4", irq, (code != 0), "irq level");
      check("R2", cap_open, (code == 0 && k >= 2), "capture window");
    end
    check(ovf ? "R6" : ((code == 2) ? "R5" : "R4"), irq_status,
          {29'd0, ovf, 2'(code)}, "end status");
    for (int a = 0; a < stored + 2; a++) begin
      rd_addr = AW'(a);
      @(negedge clk);
      if (a == 0) ev = DW'(exp_seq);
      else if (a == 1) ev = DW'(exp_prev);
      else ev = exp_mem[a];
      check((a < 2) ? "R9" : "R3 R10", rd_data, ev, "buffer word");
    end
    check("R7", irq, 1, "irq held before ack");
    last_stored = stored;
  endtask

  task automatic close_event(input bit auto_next);
    cfg_auto_rearm = auto_next;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    exp_seq = (exp_seq + 1) & ((1 << DW) - 1);
    exp_prev = last_stored;
    check("R7", irq, 0, "irq after ack");
    check("R8", busy, auto_next, "busy after ack");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit run_on;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", busy, 0, "busy after reset");
    check("R1", cap_open, 0, "window after reset");
    check("R1", irq, 0, "irq after reset");
    check("R1", irq_status, 0, "status after reset");
    // R7: ack while idle does nothing, even with auto re-arm set
    cfg_auto_rearm = 1'b1;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check("R7", busy, 0, "busy after stray ack");
    // R4 gap limit 0 acts as 1; junk before the window (R3); R1 first header
    run_event(1'b0, 5, 0, 0, 1'b1, -1, 1000, 0);
    close_event(1'b0);
    // R5 tie: gap end and event limit on the same edge, gap wins
    run_event(1'b0, 1, 0, 0, 1'b0, -1, 8, 5);
    close_event(1'b1);
    // R5 event limit with continuous data; pokes of arm and ack mid-event (R7 R8)
    run_event(1'b1, 100, 0, 0, 1'b0, 10, 20, 3);
    close_event(1'b1);
    // R5 no data, limit 0 acts as 3
    run_event(1'b1, 0, 0, 0, 1'b0, -1, 0, 4);
    close_event(1'b0);
    // R6 overflow with a full buffer
    run_event(1'b0, DEPTH, 0, 2, 1'b0, -1, 5000, 6);
    close_event(1'b0);
    // Random events
    run_on = 1'b0;
    for (int e = 0; e < 14; e++) begin
      int g;
      int mg;
      bit nxt;
      g = int'($urandom_range(8, 2));
      mg = ($urandom_range(3, 0) == 0) ? g + 1 : int'($urandom_range(g - 1, 0));
      run_event(run_on, int'($urandom_range(40, 1)), mg, int'($urandom_range(4, 0)),
                1'($urandom_range(1, 0)),
                ($urandom_range(1, 0) == 1) ? int'($urandom_range(30, 1)) : -1,
                int'($urandom_range(600, 50)), g);
      nxt = 1'($urandom_range(1, 0));
      close_event(nxt);
      run_on = nxt;
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule